// File: doc/BRIEF.md
# Branch Target and Direction Predictor

This block sits in the fetch stage and guesses, for each fetch address, whether a branch lives there, where it goes and whether it will be taken. It has two parts. A fully associative target cache maps a word-aligned fetch address to a predicted target and keeps its entries in least-recently-used order. A direct-indexed table of two-bit saturating counters gives the taken or not-taken direction. Both parts are read by a single lookup port and trained by a single update port that carries the resolved branch address, its outcome and its real target.

The block also limits speculation. Every lookup that hits the target cache counts as one predicted branch in flight. The count drops when the update port reports the resolution of a predicted branch. When the limit is reached the block drops its ready flag and ignores lookups until a branch resolves. Decode, return prediction and flush control belong to the surrounding pipeline.

Top module: `bp_fetch_predictor`

## Requirements
- R1: After reset every target cache entry is invalid and every direction counter holds weakly not-taken (2'b01), so a lookup reports pred_hit = 0, pred_taken = 0 and pred_target = 0, and lk_ready is 1.
- R2: An accepted lookup (lk_valid and lk_ready both high at a clock edge) makes pred_valid high for exactly the one cycle that follows; a lookup that is not accepted gives no pred_valid.
- R3: A taken update whose address misses the target cache allocates an entry, so a later lookup of that address hits and returns the update's target.
- R4: A not-taken update whose address misses the target cache allocates nothing; a later lookup of that address still misses.
- R5: Counter codes are 2'b00 strongly not-taken, 2'b01 weakly not-taken, 2'b10 weakly taken, 2'b11 strongly taken; pred_taken is the upper bit. A taken update adds one, a not-taken update subtracts one, and both ends saturate.
- R6: The counter is chosen by fetch address bits [12:2] (11 bits with the default 2048 entries), so two addresses 8192 bytes apart share one counter; the direction is reported whether or not the target cache hits.
- R7: A taken update whose address hits the target cache overwrites that entry's target; a not-taken update leaves the target as it was.
- R8: When every entry is valid, an allocation replaces the entry used least recently, where both a lookup hit and an update of an entry count as a use.
- R9: At most 4 predicted branches may be unresolved; with 4 outstanding lk_ready is 0 and a lookup is ignored, and an update with upd_was_pred set frees one slot in the next cycle.
- R10: When a lookup and an update address the same branch in one cycle, the lookup reports the values held before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Fetch address to predict |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| pred_valid | output | 1 | Prediction result is present |
| pred_hit | output | 1 | Target cache held the fetch address |
| pred_target | output | 32 | Predicted target, zero on a miss |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Branch resolution present |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | 32 | Resolved target address |
| upd_was_pred | input | 1 | Resolved branch was one counted as in flight |

## Verification
Prediction results are registered, so hit, target and direction of a lookup accepted at one rising edge appear after that edge and are held only until the next one; the bench drives on the falling edge and reads them on the following falling edge. Training takes effect at the edge that samples the update, so a lookup launched one cycle later already sees it, while a lookup in the same cycle sees the old state. The in-flight count grows at the edge after a hit result is shown but lk_ready already accounts for that pending hit, so the bench reads lk_ready on the falling edge right after the fourth hit and again one cycle after a resolving update.

// File: rtl/bp_pkg.sv
package bp_pkg;

   typedef enum logic [1:0] {
      CTR_STRONG_NT = 2'b00,
      CTR_WEAK_NT   = 2'b01,
      CTR_WEAK_T    = 2'b10,
      CTR_STRONG_T  = 2'b11
   } bp_ctr_e;

   function automatic logic [1:0] ctr_train(input logic [1:0] cur, input logic taken);
      logic [1:0] nxt;
      if (taken) nxt = (cur == 2'b11) ? cur : cur + 2'd1;
      else       nxt = (cur == 2'b00) ? cur : cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/bp_history_table.sv
module bp_history_table
   import bp_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_en,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              rd_taken,
   input  logic              up_en,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic              up_taken
);
   localparam int IDX_W = $clog2(ENTRIES);

   if ((1 << IDX_W) != ENTRIES) begin : g_chk_pow2
      $error("history table depth must be a power of two");
   end
   if (IDX_W + 2 > ADDR_W) begin : g_chk_width
      $error("address too narrow for history index");
   end

   logic [1:0]       cnt_q [ENTRIES];
   logic [IDX_W-1:0] lk_idx, up_idx;

   assign lk_idx = lk_addr[IDX_W+1:2];
   assign up_idx = up_addr[IDX_W+1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= CTR_WEAK_NT;
         rd_taken <= 1'b0;
      end else begin
         if (up_en) cnt_q[up_idx] <= ctr_train(cnt_q[up_idx], up_taken);
         if (lk_en) rd_taken <= cnt_q[lk_idx][1];
      end
   end

   // R5: counters stick at both ends
   p_sat_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_en && up_taken && cnt_q[up_idx] == 2'b11) |=> cnt_q[$past(up_idx)] == 2'b11);
   p_sat_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_en && !up_taken && cnt_q[up_idx] == 2'b00) |=> cnt_q[$past(up_idx)] == 2'b00);

endmodule

// File: rtl/bp_target_cache.sv
module bp_target_cache #(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_en,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              rd_hit,
   output logic [ADDR_W-1:0] rd_target,
   input  logic              up_en,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic              up_taken,
   input  logic [ADDR_W-1:0] up_target
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TAG_W = ADDR_W - 2;

   if ((1 << IDX_W) != ENTRIES || ENTRIES < 2) begin : g_chk_depth
      $error("target cache depth must be a power of two of at least 2");
   end

   logic [TAG_W-1:0]  tag_q  [ENTRIES];
   logic [ADDR_W-1:0] tgt_q  [ENTRIES];
   logic [IDX_W-1:0]  rank_q [ENTRIES];
   logic [ENTRIES-1:0] vld_q;

   logic [ENTRIES-1:0] lk_match, up_match, rank_zero;
   logic [TAG_W-1:0]   lk_tag, up_tag;
   logic               lk_hit, up_hit;
   logic [IDX_W-1:0]   lk_idx, up_idx, victim_idx;
   logic               wr_en, alloc_en, tgt_en, touch_en;
   logic [IDX_W-1:0]   wr_idx, touch_idx, touch_rank;

   assign lk_tag = lk_addr[ADDR_W-1:2];
   assign up_tag = up_addr[ADDR_W-1:2];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cam
      assign lk_match[g]  = vld_q[g] && (tag_q[g] == lk_tag);
      assign up_match[g]  = vld_q[g] && (tag_q[g] == up_tag);
      assign rank_zero[g] = (rank_q[g] == '0);
   end

   always_comb begin
      lk_idx     = '0;
      up_idx     = '0;
      victim_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_match[i])  lk_idx     = IDX_W'(i);
         if (up_match[i])  up_idx     = IDX_W'(i);
         if (rank_zero[i]) victim_idx = IDX_W'(i);
      end
   end

   assign lk_hit = |lk_match;
   assign up_hit = |up_match;

   always_comb begin
      wr_en      = up_en && (up_hit || up_taken);
      alloc_en   = up_en && !up_hit && up_taken;
      tgt_en     = up_en && up_taken;
      wr_idx     = up_hit ? up_idx : victim_idx;
      touch_en   = wr_en || (lk_en && lk_hit);
      touch_idx  = wr_en ? wr_idx : lk_idx;
      touch_rank = rank_q[touch_idx];
   end

   // Tag and target storage carries no reset; valid bits guard it.
   always_ff @(posedge clk) begin
      if (alloc_en) tag_q[wr_idx] <= up_tag;
      if (tgt_en)   tgt_q[wr_idx] <= up_target;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q     <= '0;
         rd_hit    <= 1'b0;
         rd_target <= '0;
         for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
      end else begin
         if (alloc_en) vld_q[wr_idx] <= 1'b1;
         if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
               if (IDX_W'(i) == touch_idx)      rank_q[i] <= '1;
               else if (rank_q[i] > touch_rank) rank_q[i] <= rank_q[i] - 1'b1;
            end
         end
         if (lk_en) begin
            rd_hit    <= lk_hit;
            rd_target <= lk_hit ? tgt_q[lk_idx] : '0;
         end
      end
   end

   // R8: ranks stay a permutation with a single oldest entry
   p_one_oldest_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rank_zero) == 1);
   // R8: the entry just used becomes the newest
   p_touch_newest_r8: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> rank_q[$past(touch_idx)] == '1);
   // R4: a not-taken miss leaves the valid set untouched
   p_no_alloc_nt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_en && !up_taken) |=> $stable(vld_q));

endmodule

// File: rtl/bp_inflight_limiter.sv
module bp_inflight_limiter #(
   parameter int MAX_INFLIGHT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   input  logic resolve,
   output logic ready
);
   localparam int CNT_W = $clog2(MAX_INFLIGHT + 1);

   if (MAX_INFLIGHT < 1) begin : g_chk_max
      $error("in-flight limit must be at least one");
   end

   logic [CNT_W-1:0] count_q, count_eff;

   // A hit shown this cycle is already counted toward the limit.
   assign count_eff = count_q + CNT_W'(issue);
   assign ready     = (count_eff < CNT_W'(MAX_INFLIGHT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_eff - CNT_W'(resolve && (count_eff != '0));
   end

   // R9: the outstanding count never passes the limit
   p_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(MAX_INFLIGHT));
   // R9: with no hits arriving and a resolve, the count falls by one
   p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue && resolve && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

endmodule

// File: rtl/bp_fetch_predictor.sv
module bp_fetch_predictor #(
   parameter int ADDR_W       = 32,
   parameter int BTC_ENTRIES  = 256,
   parameter int BHT_ENTRIES  = 2048,
   parameter int MAX_INFLIGHT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_ready,
   output logic              pred_valid,
   output logic              pred_hit,
   output logic [ADDR_W-1:0] pred_target,
   output logic              pred_taken,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic              upd_taken,
   input  logic [ADDR_W-1:0] upd_target,
   input  logic              upd_was_pred
);
   logic lk_fire;
   logic btc_hit;

   assign lk_fire = lk_valid && lk_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pred_valid <= 1'b0;
      else        pred_valid <= lk_fire;
   end

   bp_target_cache #(
      .ADDR_W (ADDR_W),
      .ENTRIES(BTC_ENTRIES)
   ) u_btc (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_en    (lk_fire),
      .lk_addr  (lk_addr),
      .rd_hit   (btc_hit),
      .rd_target(pred_target),
      .up_en    (upd_valid),
      .up_addr  (upd_addr),
      .up_taken (upd_taken),
      .up_target(upd_target)
   );

   bp_history_table #(
      .ADDR_W (ADDR_W),
      .ENTRIES(BHT_ENTRIES)
   ) u_bht (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_en   (lk_fire),
      .lk_addr (lk_addr),
      .rd_taken(pred_taken),
      .up_en   (upd_valid),
      .up_addr (upd_addr),
      .up_taken(upd_taken)
   );

   bp_inflight_limiter #(
      .MAX_INFLIGHT(MAX_INFLIGHT)
   ) u_lim (
      .clk    (clk),
      .rst_n  (rst_n),
      .issue  (pred_valid && btc_hit),
      .resolve(upd_valid && upd_was_pred),
      .ready  (lk_ready)
   );

   assign pred_hit = btc_hit;

   // R2: one result cycle per accepted lookup, none otherwise
   p_result_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_ready) |=> pred_valid);
   p_no_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_valid && lk_ready) |=> !pred_valid);
   // R1: a miss reports a zero target
   p_miss_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_valid && !pred_hit) |-> pred_target == '0);

endmodule

// File: tb/bp_fetch_predictor_tb_top.sv
module bp_fetch_predictor_tb_top;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 1'b0;
   logic [AW-1:0] lk_addr = '0;
   logic          lk_ready;
   logic          pred_valid, pred_hit, pred_taken;
   logic [AW-1:0] pred_target;
   logic          upd_valid = 1'b0;
   logic [AW-1:0] upd_addr = '0;
   logic          upd_taken = 1'b0;
   logic [AW-1:0] upd_target = '0;
   logic          upd_was_pred = 1'b0;

   int checks = 0;
   int errors = 0;
   int outstanding = 0;
   bit finished = 1'b0;

   logic          r_valid, r_hit, r_taken;
   logic [AW-1:0] r_target;

   localparam logic [AW-1:0] DUMMY = 32'h1000_0700;

   always #2.5 clk = ~clk;

   bp_fetch_predictor dut_i (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
      .pred_valid(pred_valid), .pred_hit(pred_hit),
      .pred_target(pred_target), .pred_taken(pred_taken),
      .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
      .upd_target(upd_target), .upd_was_pred(upd_was_pred)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive at a falling edge, result sampled at the next falling edge.
   task automatic lookup(input logic [AW-1:0] a);
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = a;
      @(negedge clk);
      lk_valid = 1'b0;
      r_valid = pred_valid; r_hit = pred_hit; r_taken = pred_taken; r_target = pred_target;
      if (pred_valid && pred_hit) outstanding++;
   endtask

   task automatic update(input logic [AW-1:0] a, input logic tk,
                         input logic [AW-1:0] t, input logic wp);
      @(negedge clk);
      upd_valid = 1'b1; upd_addr = a; upd_taken = tk; upd_target = t; upd_was_pred = wp;
      @(negedge clk);
      upd_valid = 1'b0; upd_was_pred = 1'b0;
   endtask

   task automatic drain();
      while (outstanding > 0) begin
         update(DUMMY, 1'b0, '0, 1'b1);
         outstanding--;
      end
   endtask

   task automatic t_reset_state();
      check("R1 lk_ready after reset", lk_ready, 1);
      check("R2 pred_valid idle", pred_valid, 0);
      lookup(32'h1000_0000);
      check("R2 pred_valid after lookup", r_valid, 1);
      check("R1 no hit after reset", r_hit, 0);
      check("R1 weakly not-taken after reset", r_taken, 0);
      check("R1 miss target zero", r_target, 0);
      @(negedge clk);
      check("R2 pred_valid one cycle only", pred_valid, 0);
   endtask

   task automatic t_alloc();
      update(32'h1000_0100, 1'b1, 32'h2000_0000, 1'b0);
      lookup(32'h1000_0100);
      check("R3 taken miss allocates", r_hit, 1);
      check("R3 allocated target", r_target, 32'h2000_0000);
      update(32'h1000_0100, 1'b1, 32'h2000_0400, 1'b0);
      lookup(32'h1000_0100);
      check("R7 taken hit rewrites target", r_target, 32'h2000_0400);
      update(32'h1000_0100, 1'b0, 32'h2000_0800, 1'b0);
      lookup(32'h1000_0100);
      check("R7 not-taken keeps target", r_target, 32'h2000_0400);
      update(32'h1000_0200, 1'b0, 32'h2000_0c00, 1'b0);
      lookup(32'h1000_0200);
      check("R4 not-taken miss no allocation", r_hit, 0);
      drain();
   endtask

   task automatic t_counter();
      logic [AW-1:0] s;
      s = 32'h1000_0300;
      for (int i = 0; i < 3; i++) update(s, 1'b1, 32'h2100_0000, 1'b0);
      update(s, 1'b0, '0, 1'b0);
      lookup(s);
      check("R5 high saturation then one down stays taken", r_taken, 1);
      update(s, 1'b0, '0, 1'b0);
      lookup(s);
      check("R5 two down from top is not-taken", r_taken, 0);
      for (int i = 0; i < 3; i++) update(s, 1'b0, '0, 1'b0);
      update(s, 1'b1, 32'h2100_0000, 1'b0);
      lookup(s);
      check("R5 low saturation then one up stays not-taken", r_taken, 0);
      update(s, 1'b1, 32'h2100_0000, 1'b0);
      lookup(s);
      check("R5 two up from bottom is taken", r_taken, 1);
      drain();
   endtask

   task automatic t_alias();
      update(32'h1000_0400, 1'b1, 32'h2200_0000, 1'b0);
      lookup(32'h1000_2400);
      check("R6 alias misses target cache", r_hit, 0);
      check("R6 alias shares counter", r_taken, 1);
      lookup(32'h1000_0404);
      check("R6 neighbour word keeps own counter", r_taken, 0);
      drain();
   endtask

   task automatic t_same_cycle();
      logic [AW-1:0] q;
      q = 32'h1000_0500;
      update(q, 1'b1, 32'h3000_0000, 1'b0);
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = q;
      upd_valid = 1'b1; upd_addr = q; upd_taken = 1'b1; upd_target = 32'h3000_0800;
      @(negedge clk);
      lk_valid = 1'b0; upd_valid = 1'b0;
      if (pred_valid && pred_hit) outstanding++;
      check("R10 same-cycle lookup sees old target", pred_target, 32'h3000_0000);
      lookup(q);
      check("R10 later lookup sees new target", r_target, 32'h3000_0800);
      drain();
   endtask

   task automatic t_limit();
      logic [AW-1:0] x;
      x = 32'h1000_0600;
      update(x, 1'b1, 32'h4000_0000, 1'b0);
      for (int i = 0; i < 3; i++) lookup(x);
      check("R9 ready with three outstanding", lk_ready, 1);
      lookup(x);
      check("R9 ready low at limit", lk_ready, 0);
      lookup(x);
      check("R9 lookup ignored at limit", r_valid, 0);
      update(x, 1'b1, 32'h4000_0000, 1'b1);
      outstanding--;
      check("R9 ready after one resolve", lk_ready, 1);
      lookup(x);
      check("R9 lookup accepted after resolve", r_valid, 1);
      drain();
   endtask

   task automatic t_lru();
      logic [AW-1:0] base;
      base = 32'h1100_0000;
      for (int i = 0; i < 256; i++) update(base + AW'(4 * i), 1'b1, 32'h5000_0000 + AW'(i), 1'b0);
      lookup(32'h1000_0100);
      check("R8 oldest entries evicted by fill", r_hit, 0);
      lookup(base);
      check("R8 first filled entry still present", r_hit, 1);
      update(32'h1100_1000, 1'b1, 32'h6000_0000, 1'b0);
      lookup(base + 32'd4);
      check("R8 least recently used entry replaced", r_hit, 0);
      lookup(base);
      check("R8 recently looked-up entry kept", r_hit, 1);
      lookup(base + 32'd8);
      check("R8 next entry kept", r_target, 32'h5000_0002);
      lookup(32'h1100_1000);
      check("R8 new entry present", r_target, 32'h6000_0000);
      drain();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_alloc();
      t_counter();
      t_alias();
      t_same_cycle();
      t_limit();
      t_lru();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule